// File: doc/BRIEF.md
# Reference-Disciplined Fractional Clock Divider

The block turns a free-running system clock of roughly 4 MHz into a 32.768 kHz clock-enable pulse whose average rate is tied to a one-pulse-per-second timing reference. The system clock does not divide to 32768 Hz by any whole number. The divider therefore runs two neighbouring integer ratios, a short one of q clocks and a long one of q+1 clocks. A phase accumulator interleaves them in a fixed pattern, so that 2^OUT_BITS output periods (32768 by default) span exactly N system clocks.

A free-running counter measures N, the number of system clocks between consecutive reference edges, and splits it into q = N >> OUT_BITS and r = N mod 2^OUT_BITS. The divider then applies that pair for the next second. Measurements that fall outside a tolerance window around the nominal count are treated as a glitch or a missing pulse and are not applied. A lock flag shows whether recent measurements were accepted. Every reference edge restarts the output pattern, so each second begins phase-aligned. The result has no long-term drift relative to the reference.

Top module: `ppsd_divider`

## Requirements
- R1: While reset is held and in the cycles just after it, lockOut is 0 and periodOut is 0.
- R2: On each rising edge of ppsIn after the first one since reset, periodOut takes the number of system clocks since the previous rising edge. This happens whether or not the value is accepted. The count saturates at its all-ones value.
- R3: When the interval N between reference edges stays constant and lies inside the window, tickOut pulses exactly 2^OUT_BITS times between one reference edge and the next.
- R4: Under an accepted period N, consecutive tickOut pulses are q = N >> OUT_BITS clocks or q+1 clocks apart. The count of q+1 gaps in one interval equals N mod 2^OUT_BITS. tickOut is never high in two adjacent cycles.
- R5: Until the first accepted measurement, the divider uses the nominal pair, q = NOMINAL_CLOCKS >> OUT_BITS and r = NOMINAL_CLOCKS mod 2^OUT_BITS. Tick gaps are therefore only q or q+1.
- R6: A period is accepted only when |N − NOMINAL_CLOCKS| ≤ (NOMINAL_CLOCKS/1000)·TOL_PPM/1000. A rejected period leaves the ratio pair in force unchanged.
- R7: lockOut rises on the first accepted measurement. It stays high through a single rejection and falls on the second consecutive rejection. It returns high on the next accepted measurement.
- R8: Every rising edge of ppsIn restarts the pattern, whatever the phase of the output. Let the first clock edge that samples ppsIn high be edge 0. tickOut is next high in the cycle after clock edge q+1, where q is the ratio in force after the restart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, nominally 4 MHz |
| rst | input | 1 | Synchronous active-high reset |
| ppsIn | input | 1 | Asynchronous one-pulse-per-second reference |
| tickOut | output | 1 | One-cycle enable at the divided output rate |
| lockOut | output | 1 | High while recent measurements were accepted |
| periodOut | output | $clog2(NOMINAL_CLOCKS)+2 | Most recent measured reference interval, in system clocks |

## Verification
The bench builds the block with NOMINAL_CLOCKS = 4000, OUT_BITS = 8 and TOL_PPM = 20000. One "second" is then 4000 clocks holding 256 ticks, with q = 15, and the tolerance window is ±80 clocks. These values put multi-second sequences within reach: randomly drawn periods across the whole window, a missing pulse, and a pair of misplaced pulses that drops lock. Each of them can be checked against exact tick counts and long-gap counts computed from N.

// File: rtl/ppsd_pkg.sv
package ppsd_pkg;
  // Strobes issued by the control to the datapath, all single-cycle.
  typedef struct packed {
    logic restart;  // reference edge seen: realign the output pattern
    logic report;   // a full interval has been measured
    logic load;     // the measured interval is accepted as the new ratio
  } ppsdStrobes_t;
endpackage

// File: rtl/ppsd_sync_edge.sv
module ppsd_sync_edge (
  input  logic clk,
  input  logic rst,
  input  logic ppsIn,
  output logic ppsEdge
);
  // Two synchronizer flops plus one history flop for the edge detect.
  logic [2:0] shiftQ;

  always_ff @(posedge clk) begin
    if (rst) shiftQ <= '0;
    else     shiftQ <= {shiftQ[1:0], ppsIn};
  end

  assign ppsEdge = shiftQ[1] & ~shiftQ[2];
endmodule

// File: rtl/ppsd_control.sv
module ppsd_control
  import ppsd_pkg::*;
#(
  parameter int CNT_W          = 24,
  parameter int NOMINAL_CLOCKS = 4000000,
  parameter int TOL_CLOCKS     = 800
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ppsEdge,
  input  logic [CNT_W-1:0] measuredNow,
  output ppsdStrobes_t     strobes,
  output logic             lockOut
);
  localparam logic [CNT_W-1:0] LO_V = CNT_W'(NOMINAL_CLOCKS - TOL_CLOCKS);
  localparam logic [CNT_W-1:0] HI_V = CNT_W'(NOMINAL_CLOCKS + TOL_CLOCKS);

  logic haveRef;   // an earlier edge exists, so the interval is meaningful
  logic strike;    // last measurement was rejected
  logic inWindow;

  assign inWindow        = (measuredNow >= LO_V) && (measuredNow <= HI_V);
  assign strobes.restart = ppsEdge;
  assign strobes.report  = ppsEdge & haveRef;
  assign strobes.load    = ppsEdge & haveRef & inWindow;

  always_ff @(posedge clk) begin
    if (rst) begin
      haveRef <= 1'b0;
      strike  <= 1'b0;
      lockOut <= 1'b0;
    end else begin
      if (ppsEdge) haveRef <= 1'b1;
      if (strobes.report) begin
        if (inWindow) begin
          lockOut <= 1'b1;
          strike  <= 1'b0;
        end else if (strike) begin
          lockOut <= 1'b0;
        end else begin
          strike <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ppsd_datapath.sv
module ppsd_datapath
  import ppsd_pkg::*;
#(
  parameter int CNT_W          = 24,
  parameter int OUT_BITS       = 15,
  parameter int NOMINAL_CLOCKS = 4000000
) (
  input  logic             clk,
  input  logic             rst,
  input  ppsdStrobes_t     strobes,
  output logic [CNT_W-1:0] measuredNow,
  output logic [CNT_W-1:0] periodOut,
  output logic             tickOut
);
  localparam int Q_W = CNT_W - OUT_BITS;
  localparam logic [Q_W-1:0]      NOM_Q = Q_W'(NOMINAL_CLOCKS >> OUT_BITS);
  localparam logic [OUT_BITS-1:0] NOM_R = OUT_BITS'(NOMINAL_CLOCKS % (1 << OUT_BITS));

  // Interval measurement
  logic [CNT_W-1:0] periodCnt;

  assign measuredNow = (periodCnt == '1) ? periodCnt : periodCnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst)                  periodCnt <= '0;
    else if (strobes.restart) periodCnt <= '0;
    else if (periodCnt != '1) periodCnt <= periodCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                 periodOut <= '0;
    else if (strobes.report) periodOut <= measuredNow;
  end

  // Ratio pair in force
  logic [Q_W-1:0]      activeQ, nextQ;
  logic [OUT_BITS-1:0] activeR, nextR;

  assign nextQ = strobes.load ? measuredNow[CNT_W-1:OUT_BITS] : activeQ;
  assign nextR = strobes.load ? measuredNow[OUT_BITS-1:0]     : activeR;

  always_ff @(posedge clk) begin
    if (rst) begin
      activeQ <= NOM_Q;
      activeR <= NOM_R;
    end else if (strobes.load) begin
      activeQ <= nextQ;
      activeR <= nextR;
    end
  end

  // Dual-ratio divider steered by the phase accumulator
  logic [Q_W-1:0]      divCnt;
  logic [OUT_BITS-1:0] accState;
  logic [OUT_BITS:0]   accSum;

  assign accSum  = {1'b0, accState} + {1'b0, activeR};
  assign tickOut = (divCnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      divCnt   <= NOM_Q - 1'b1;
      accState <= NOM_R;
    end else if (strobes.restart) begin
      // First period of a second: accumulator starts from zero, so r is
      // added without carry and the short ratio is used.
      divCnt   <= nextQ - 1'b1;
      accState <= nextR;
    end else if (tickOut) begin
      accState <= accSum[OUT_BITS-1:0];
      divCnt   <= accSum[OUT_BITS] ? activeQ : activeQ - 1'b1;
    end else begin
      divCnt <= divCnt - 1'b1;
    end
  end
endmodule

// File: rtl/ppsd_divider.sv
module ppsd_divider
  import ppsd_pkg::*;
#(
  parameter  int NOMINAL_CLOCKS = 4000000,
  parameter  int OUT_BITS       = 15,
  parameter  int TOL_PPM        = 200,
  localparam int CNT_W          = $clog2(NOMINAL_CLOCKS) + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ppsIn,
  output logic             tickOut,
  output logic             lockOut,
  output logic [CNT_W-1:0] periodOut
);
  localparam int TOL_CLOCKS = (NOMINAL_CLOCKS / 1000) * TOL_PPM / 1000;

  logic             ppsEdge;
  logic [CNT_W-1:0] measuredNow;
  ppsdStrobes_t     strobes;
  logic             restartStb, reportStb;

  assign restartStb = strobes.restart;
  assign reportStb  = strobes.report;

  ppsd_sync_edge u_sync (
    .clk(clk), .rst(rst), .ppsIn(ppsIn), .ppsEdge(ppsEdge)
  );

  ppsd_control #(
    .CNT_W(CNT_W), .NOMINAL_CLOCKS(NOMINAL_CLOCKS), .TOL_CLOCKS(TOL_CLOCKS)
  ) u_ctrl (
    .clk(clk), .rst(rst), .ppsEdge(ppsEdge), .measuredNow(measuredNow),
    .strobes(strobes), .lockOut(lockOut)
  );

  ppsd_datapath #(
    .CNT_W(CNT_W), .OUT_BITS(OUT_BITS), .NOMINAL_CLOCKS(NOMINAL_CLOCKS)
  ) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .measuredNow(measuredNow),
    .periodOut(periodOut), .tickOut(tickOut)
  );
endmodule

// File: rtl/ppsd_checker.sv
module ppsd_checker #(
  parameter  int NOMINAL_CLOCKS = 4000000,
  parameter  int OUT_BITS       = 15,
  parameter  int TOL_PPM        = 200,
  localparam int CNT_W          = $clog2(NOMINAL_CLOCKS) + 2
) (
  input logic             clk,
  input logic             rst,
  input logic             tickOut,
  input logic             lockOut,
  input logic [CNT_W-1:0] periodOut,
  input logic             restartStb,
  input logic             reportStb
);
  localparam int TOL_CLOCKS = (NOMINAL_CLOCKS / 1000) * TOL_PPM / 1000;
  localparam logic [CNT_W-1:0] LO_V = CNT_W'(NOMINAL_CLOCKS - TOL_CLOCKS);
  localparam logic [CNT_W-1:0] HI_V = CNT_W'(NOMINAL_CLOCKS + TOL_CLOCKS);

  logic periodOk;
  assign periodOk = (periodOut >= LO_V) && (periodOut <= HI_V);

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
    tickOut |=> !tickOut); // R4

  AST_RESTART_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    restartStb |=> !tickOut); // R8

  AST_PERIOD_ON_REPORT: assert property (@(posedge clk) disable iff (rst)
    !$stable(periodOut) |-> $past(reportStb)); // R2

  AST_LOCK_RISE_VALID: assert property (@(posedge clk) disable iff (rst)
    $rose(lockOut) |-> (periodOk && $past(reportStb))); // R7

  AST_LOCK_FALL_INVALID: assert property (@(posedge clk) disable iff (rst)
    $fell(lockOut) |-> (!periodOk && $past(reportStb))); // R7
endmodule

bind ppsd_divider ppsd_checker #(
  .NOMINAL_CLOCKS(NOMINAL_CLOCKS), .OUT_BITS(OUT_BITS), .TOL_PPM(TOL_PPM)
) u_chk (
  .clk(clk), .rst(rst), .tickOut(tickOut), .lockOut(lockOut),
  .periodOut(periodOut), .restartStb(restartStb), .reportStb(reportStb)
);

// File: tb/sim_ppsd_divider.sv
module sim_ppsd_divider;
  localparam int NOM = 4000;
  localparam int FB  = 8;
  localparam int PPM = 20000;
  localparam int CW  = $clog2(NOM) + 2;
  localparam int QEXP = NOM >> FB;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ppsIn = 1'b0;
  logic tickOut, lockOut;
  logic [CW-1:0] periodOut;

  always #10 clk = ~clk;

  ppsd_divider #(.NOMINAL_CLOCKS(NOM), .OUT_BITS(FB), .TOL_PPM(PPM)) u0 (
    .clk(clk), .rst(rst), .ppsIn(ppsIn), .tickOut(tickOut),
    .lockOut(lockOut), .periodOut(periodOut)
  );

  int checks = 0, fails = 0, cyc = 0, lastTick = -1;
  int curTicks = 0, curLong = 0, curBad = 0;
  int winTicks = 0, winLong = 0, winBad = 0;
  int firstOff = -1;

  function automatic int qOf(int n); return n >> FB; endfunction
  function automatic int rOf(int n); return n % (1 << FB); endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    int sp;
    @(negedge clk);
    cyc++;
    if (tickOut) begin
      curTicks++;
      if (lastTick >= 0) begin
        sp = cyc - lastTick;
        if (sp == QEXP + 1) curLong++;
        else if (sp != QEXP) curBad++;
      end
      lastTick = cyc;
    end
  endtask

  task automatic clearStats();
    curTicks = 0; curLong = 0; curBad = 0; lastTick = -1;
  endtask

  // One reference interval of n clocks, starting with a PPS rise.
  task automatic runSecond(int n);
    ppsIn = 1'b1;
    firstOff = -1;
    for (int i = 1; i <= n; i++) begin
      step();
      if (i == 2) begin
        winTicks = curTicks; winLong = curLong; winBad = curBad;
        clearStats();
      end
      if (i >= 3 && tickOut && firstOff < 0) firstOff = i;
      if (i == 10) ppsIn = 1'b0;
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    summary();
    $finish;
  end

  initial begin
    int n, m;
    void'($urandom(32'h5eed));
    repeat (4) step();
    chk(lockOut == 1'b0, "R1", "lock in reset", lockOut, 0);
    rst = 1'b0;
    repeat (3) step();
    chk(lockOut == 1'b0, "R1", "lock after reset", lockOut, 0);
    chk(periodOut == '0, "R1", "period after reset", periodOut, 0);

    // Pre-lock: nominal ratio only
    clearStats();
    repeat (3000) step();
    chk(curBad == 0, "R5", "pre-lock bad gaps", curBad, 0);
    chk(curLong > 0 && curTicks > 180, "R5", "pre-lock long gaps", curLong, 1);

    runSecond(NOM);
    chk(lockOut == 1'b0, "R7", "no lock before a measurement", lockOut, 0);
    runSecond(NOM);
    chk(periodOut == CW'(NOM), "R2", "first period", periodOut, NOM);
    chk(lockOut == 1'b1, "R7", "lock on first accept", lockOut, 1);
    runSecond(NOM);
    chk(winTicks == (1 << FB), "R3", "ticks per second", winTicks, 1 << FB);
    chk(winLong == rOf(NOM), "R4", "long gaps", winLong, rOf(NOM));
    chk(firstOff == qOf(NOM) + 2, "R8", "first tick offset", firstOff, qOf(NOM) + 2);

    // Random periods across the window
    for (int k = 0; k < 5; k++) begin
      n = 3925 + int'($urandom % 151);
      runSecond(n); runSecond(n); runSecond(n);
      chk(periodOut == CW'(n), "R2", "random period", periodOut, n);
      chk(winTicks == (1 << FB), "R3", "random ticks", winTicks, 1 << FB);
      chk(winLong == rOf(n), "R4", "random long gaps", winLong, rOf(n));
      chk(winBad == 0, "R4", "random bad gaps", winBad, 0);
    end

    // Missing pulse: one rejection, ratio kept, lock held
    m = 4010;
    runSecond(m); runSecond(m);
    runSecond(2 * m);
    runSecond(m);
    chk(periodOut == CW'(2 * m), "R2", "rejected period reported", periodOut, 2 * m);
    chk(lockOut == 1'b1, "R7", "lock after one rejection", lockOut, 1);
    runSecond(m);
    chk(winTicks == (1 << FB), "R6", "ticks with kept ratio", winTicks, 1 << FB);
    chk(winLong == rOf(m), "R6", "long gaps with kept ratio", winLong, rOf(m));
    chk(periodOut == CW'(m), "R2", "period after recovery", periodOut, m);

    // Misplaced pulses: two rejections drop lock
    runSecond(1000);
    runSecond(3010);
    chk(lockOut == 1'b1, "R7", "lock after first glitch", lockOut, 1);
    chk(firstOff == qOf(m) + 2, "R8", "restart on misaligned edge", firstOff, qOf(m) + 2);
    runSecond(NOM);
    chk(lockOut == 1'b0, "R7", "lock after second rejection", lockOut, 0);
    chk(periodOut == CW'(3010), "R2", "short period reported", periodOut, 3010);
    runSecond(NOM);
    chk(lockOut == 1'b1, "R7", "relock", lockOut, 1);
    runSecond(NOM);
    chk(winTicks == (1 << FB), "R3", "ticks after relock", winTicks, 1 << FB);
    chk(winLong == rOf(NOM), "R4", "long gaps after relock", winLong, rOf(NOM));

    summary();
    $finish;
  end
endmodule